// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the command front end and erase controller of a parallel NOR-style flash array, modelled at the logic level. It watches bus write cycles (address, data byte, write strobe and a sector select) and recognises multi-cycle unlock sequences that start a whole-array erase or a sector erase. It also recognises a one-write erase suspend, a one-write resume and a two-write reset. Erase progress comes from counters rather than from real cells. Each sector holds an erase-set flag and a content state that reads back as original data, all zeros or all ones.

A sector erase opens a collection window. Further confirm writes add sectors to the set and restart the window's timeout. When the timeout expires, the controller pre-programs every selected sector to 00h, then applies erase pulses until the sectors verify. A sector that never verifies within the pulse budget puts the block in a failure state. Status reads taken while a command is active return a byte with a toggle bit, a failure bit and a timeout-expired bit. At other times reads return array data.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is in read-array mode, `rd_data` is 00h, and reading sector s returns A0h OR s, because every sector holds its original data.
- R2: The writes AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 10h@555h start a bulk erase of every sector. Status reads then show bit 3 = 1 from the start. In the default configuration the bulk erase ends in failure (see R11), and afterwards every sector reads 00h.
- R3: The same first five writes followed by 30h at any address start a sector erase of the addressed sector, which is `addr[11:9]`. A wrong data byte or address at any step returns the block to read-array mode, and no erase takes place.
- R4: While the collection window is open, each further 30h write adds the addressed sector to the erase set and restarts the TMO_CYC-cycle timeout. Status reads show bit 3 = 0 for the whole window.
- R5: When the timeout expires, the erase runs and status reads show bit 3 = 1. When the erase completes, each erased sector reads FFh, sectors outside the set keep their data, and the block is back in read-array mode.
- R6: Inside the window, any selected write other than 30h, or B0h at an even address, aborts the erase, clears the set and returns the block to read-array mode.
- R7: During a sector erase, selected writes other than suspend and reset are ignored. During a bulk erase every write is ignored, including suspend and reset.
- R8: B0h written to an even address suspends a sector erase, and a suspend inside the window also ends the window. While suspended, the erase makes no progress. Reads of sectors outside the set return array data, and reads of sectors in the set return status with bit 3 = 1.
- R9: A 30h write during suspend resumes the erase where it stopped, and the erase then runs to completion.
- R10: Every selected sector is set to 00h before it is erased. A sector whose erase fails reads 00h after a reset.
- R11: A sector in WEAK_MASK never verifies. After MAX_PULSES pulses the block enters a failure state, in which status reads show bit 5 = 1. This state persists until a reset command.
- R12: While an erase is running (not suspended) or has failed, status bit 6 inverts on each status read.
- R13: The writes 90h then 00h, at any addresses, return the block to read-array mode. During a running or suspended sector erase this aborts the erase and leaves the sector contents as they stand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for writes and reads; the top SEC_W bits select the sector |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| sel | input | 1 | Sector select; writes count only while it is high |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read result, valid on the cycle after `rd_en` |

## Verification
The erase paths are tried with several command patterns: a clean single confirm, a window extended by a second confirm, a suspend inside the window, a suspend during pre-programming, a reset during the erase, a window aborted by a stray command or an odd-address suspend, and unlock sequences corrupted at the last byte and at the second byte. A restarted window is told apart from a single one by reading bit 3 later than one timeout after the first confirm. A frozen suspend is told apart from a running one by waiting longer than a full erase and then reading status. Bulk erase is told apart from sector erase by showing that suspend and reset writes leave the status toggle running. The pre-program step is told apart from a direct erase by the 00h contents left behind after a failure.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_U1,
        ST_U2,
        ST_U3,
        ST_U4,
        ST_U5,
        ST_RST1,
        ST_ACCUM,
        ST_PREP,
        ST_ERASE,
        ST_SUSP,
        ST_FAIL
    } st_e;

    typedef enum logic [1:0] {
        CT_DATA,
        CT_ZERO,
        CT_BLANK
    } cont_e;

    typedef struct packed {
        logic unl_a;    // AAh at 555h
        logic unl_b;    // 55h at AAAh
        logic setup;    // 80h at 555h
        logic bulk_go;  // 10h at 555h
        logic conf;     // 30h anywhere
        logic susp;     // B0h at even address
        logic rst_a;    // 90h anywhere
        logic rst_b;    // 00h anywhere
    } cmd_t;

    localparam int DQ_TOGGLE = 6;
    localparam int DQ_FAIL   = 5;
    localparam int DQ_TMO    = 3;

endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
    import fes_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output cmd_t              cmd
);
    localparam logic [ADDR_W-1:0] ADR_LO = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] ADR_HI = ADDR_W'(12'hAAA);

    logic at_lo;
    logic at_hi;

    always_comb begin
        at_lo       = (addr == ADR_LO);
        at_hi       = (addr == ADR_HI);
        cmd.unl_a   = (wdata == 8'hAA) && at_lo;
        cmd.unl_b   = (wdata == 8'h55) && at_hi;
        cmd.setup   = (wdata == 8'h80) && at_lo;
        cmd.bulk_go = (wdata == 8'h10) && at_lo;
        cmd.conf    = (wdata == 8'h30);
        cmd.susp    = (wdata == 8'hB0) && !addr[0];
        cmd.rst_a   = (wdata == 8'h90);
        cmd.rst_b   = (wdata == 8'h00);
    end
endmodule

// File: rtl/fes_sector_file.sv
module fes_sector_file
    import fes_pkg::*;
#(
    parameter int               NSEC      = 8,
    parameter int               SEC_W     = $clog2(NSEC),
    parameter logic [NSEC-1:0]  WEAK_MASK = {1'b1, {(NSEC-1){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [SEC_W-1:0] set_idx,
    input  logic             set_all,
    input  logic             clr_all,
    input  logic             prog_en,
    input  logic             erase_en,
    input  logic [SEC_W-1:0] rd_idx,
    output logic             rd_mark,
    output cont_e            rd_cont,
    output logic             weak_hit
);
    typedef struct packed {
        logic  [NSEC-1:0]        marks;
        cont_e [NSEC-1:0]        cont;
    } sfile_t;

    sfile_t sf_d;
    sfile_t sf_q;

    always_comb begin
        sf_d = sf_q;
        if (clr_all) sf_d.marks = '0;
        if (set_all) sf_d.marks = '1;
        if (set_en)  sf_d.marks[set_idx] = 1'b1;
        for (int i = 0; i < NSEC; i++) begin
            if (prog_en && sf_q.marks[i])  sf_d.cont[i] = CT_ZERO;
            if (erase_en && sf_q.marks[i]) sf_d.cont[i] = CT_BLANK;
        end
        if (erase_en) sf_d.marks = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sf_q <= '0;
        else        sf_q <= sf_d;
    end

    assign rd_mark  = sf_q.marks[rd_idx];
    assign rd_cont  = sf_q.cont[rd_idx];
    assign weak_hit = |(sf_q.marks & WEAK_MASK);

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        AST_BLANK_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (sf_q.cont[g] == CT_BLANK && $past(sf_q.cont[g]) != CT_BLANK)
            |-> $past(sf_q.cont[g]) == CT_ZERO);  // R10
    end
endmodule

// File: rtl/fes_read_mux.sv
module fes_read_mux
    import fes_pkg::*;
#(
    parameter int SEC_W = 3
) (
    input  st_e              st,
    input  logic             mark,
    input  cont_e            cont,
    input  logic [SEC_W-1:0] sec,
    input  logic             tog,
    output logic [7:0]       data,
    output logic             tog_adv
);
    logic       show_stat;
    logic [7:0] stat_b;
    logic [7:0] arr_b;

    always_comb begin
        show_stat = (st inside {ST_ACCUM, ST_PREP, ST_ERASE, ST_FAIL})
                    || (st == ST_SUSP && mark);
        tog_adv   = show_stat && (st != ST_SUSP);
        stat_b            = '0;
        stat_b[DQ_TOGGLE] = tog;
        stat_b[DQ_FAIL]   = (st == ST_FAIL);
        stat_b[DQ_TMO]    = (st != ST_ACCUM);
        case (cont)
            CT_ZERO:  arr_b = 8'h00;
            CT_BLANK: arr_b = 8'hFF;
            default:  arr_b = 8'hA0 | 8'(sec);
        endcase
        data = show_stat ? stat_b : arr_b;
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter int              NSEC       = 8,
    parameter int              TMO_CYC    = 40,
    parameter int              PREP_CYC   = 16,
    parameter int              PULSE_CYC  = 24,
    parameter int              MAX_PULSES = 3,
    parameter logic [NSEC-1:0] WEAK_MASK  = {1'b1, {(NSEC-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              sel,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);
    localparam int SEC_W = $clog2(NSEC);
    localparam int CMAX0 = (TMO_CYC > PREP_CYC) ? TMO_CYC : PREP_CYC;
    localparam int CMAX  = (CMAX0 > PULSE_CYC) ? CMAX0 : PULSE_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam int PUL_W = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        st_e              st;
        st_e              res;
        logic             bulk;
        logic             rst_pend;
        logic [CNT_W-1:0] cnt;
        logic [PUL_W-1:0] pul;
        logic             tog;
        logic [7:0]       rdata;
    } core_t;

    core_t c_d;
    core_t c_q;

    cmd_t             cmd;
    logic [SEC_W-1:0] sec;
    logic             set_en, set_all, clr_all, prog_en, erase_en;
    logic             rd_mark, weak_hit, tog_adv;
    cont_e            rd_cont;
    logic [7:0]       mux_data;
    logic             w;
    logic             take;

    assign sec = addr[ADDR_W-1 -: SEC_W];
    assign w   = wr_en && sel;

    fes_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    fes_sector_file #(.NSEC(NSEC), .SEC_W(SEC_W), .WEAK_MASK(WEAK_MASK)) u_sf (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_idx  (sec),
        .set_all  (set_all),
        .clr_all  (clr_all),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .rd_idx   (sec),
        .rd_mark  (rd_mark),
        .rd_cont  (rd_cont),
        .weak_hit (weak_hit)
    );

    fes_read_mux #(.SEC_W(SEC_W)) u_rm (
        .st      (c_q.st),
        .mark    (rd_mark),
        .cont    (rd_cont),
        .sec     (sec),
        .tog     (c_q.tog),
        .data    (mux_data),
        .tog_adv (tog_adv)
    );

    always_comb begin
        c_d      = c_q;
        set_en   = 1'b0;
        set_all  = 1'b0;
        clr_all  = 1'b0;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        take     = 1'b0;

        case (c_q.st)
            ST_READ: if (w) begin
                if (cmd.unl_a)      c_d.st = ST_U1;
                else if (cmd.rst_a) c_d.st = ST_RST1;
            end
            ST_U1: if (w) c_d.st = cmd.unl_b ? ST_U2 : ST_READ;
            ST_U2: if (w) c_d.st = cmd.setup ? ST_U3 : ST_READ;
            ST_U3: if (w) c_d.st = cmd.unl_a ? ST_U4 : ST_READ;
            ST_U4: if (w) c_d.st = cmd.unl_b ? ST_U5 : ST_READ;
            ST_U5: if (w) begin
                c_d.cnt = '0;
                c_d.pul = '0;
                if (cmd.bulk_go) begin
                    set_all  = 1'b1;
                    c_d.bulk = 1'b1;
                    c_d.st   = ST_PREP;
                end else if (cmd.conf) begin
                    set_en   = 1'b1;
                    c_d.bulk = 1'b0;
                    c_d.st   = ST_ACCUM;
                end else begin
                    c_d.st   = ST_READ;
                end
            end
            ST_RST1: if (w) c_d.st = ST_READ;
            ST_ACCUM: begin
                if (c_q.cnt == CNT_W'(TMO_CYC - 1)) begin
                    c_d.st  = ST_PREP;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
                if (w) begin
                    if (cmd.conf) begin
                        set_en  = 1'b1;
                        c_d.st  = ST_ACCUM;
                        c_d.cnt = '0;
                    end else if (cmd.susp) begin
                        c_d.st  = ST_SUSP;
                        c_d.res = ST_PREP;
                        c_d.cnt = '0;
                    end else begin
                        clr_all = 1'b1;
                        c_d.st  = ST_READ;
                        c_d.cnt = '0;
                    end
                end
            end
            ST_PREP, ST_ERASE: begin
                if (w && !c_q.bulk) begin
                    if (cmd.susp) begin
                        take    = 1'b1;
                        c_d.st  = ST_SUSP;
                        c_d.res = c_q.st;
                        c_d.rst_pend = 1'b0;
                    end else if (cmd.rst_b && c_q.rst_pend) begin
                        take    = 1'b1;
                        clr_all = 1'b1;
                        c_d.st  = ST_READ;
                        c_d.rst_pend = 1'b0;
                    end else begin
                        c_d.rst_pend = cmd.rst_a;
                    end
                end
                if (!take) begin
                    if (c_q.st == ST_PREP) begin
                        if (c_q.cnt == CNT_W'(PREP_CYC - 1)) begin
                            prog_en = 1'b1;
                            c_d.st  = ST_ERASE;
                            c_d.cnt = '0;
                            c_d.pul = '0;
                        end else begin
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                    end else if (c_q.cnt == CNT_W'(PULSE_CYC - 1)) begin
                        c_d.cnt = '0;
                        if (!weak_hit) begin
                            erase_en = 1'b1;
                            c_d.st   = ST_READ;
                            c_d.bulk = 1'b0;
                            c_d.rst_pend = 1'b0;
                        end else if (c_q.pul == PUL_W'(MAX_PULSES - 1)) begin
                            c_d.st = ST_FAIL;
                            c_d.rst_pend = 1'b0;
                        end else begin
                            c_d.pul = c_q.pul + 1'b1;
                        end
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            ST_SUSP: if (w) begin
                if (cmd.conf) begin
                    c_d.st = c_q.res;
                    c_d.rst_pend = 1'b0;
                end else if (cmd.rst_b && c_q.rst_pend) begin
                    clr_all = 1'b1;
                    c_d.st  = ST_READ;
                    c_d.rst_pend = 1'b0;
                end else begin
                    c_d.rst_pend = cmd.rst_a;
                end
            end
            ST_FAIL: if (w) begin
                if (cmd.rst_b && c_q.rst_pend) begin
                    clr_all  = 1'b1;
                    c_d.st   = ST_READ;
                    c_d.bulk = 1'b0;
                    c_d.rst_pend = 1'b0;
                end else begin
                    c_d.rst_pend = cmd.rst_a;
                end
            end
            default: c_d.st = ST_READ;
        endcase

        if (rd_en) begin
            c_d.rdata = mux_data;
            if (tog_adv) c_d.tog = ~c_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data = c_q.rdata;

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pul < PUL_W'(MAX_PULSES));  // R11
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ACCUM) |-> (c_q.cnt < CNT_W'(TMO_CYC)));  // R4
    AST_BULK_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st inside {ST_PREP, ST_ERASE}) && c_q.bulk) |=> (c_q.st != ST_SUSP));  // R7
    AST_TOG_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (c_q.st inside {ST_PREP, ST_ERASE})) |=> (c_q.tog != $past(c_q.tog)));  // R12
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FAIL && !wr_en) |=> (c_q.st == ST_FAIL));  // R11
    AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SUSP) |=> $stable(c_q.cnt));  // R8
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        sel = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;

    always #4 clk = ~clk;

    flash_erase_seq uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .sel(sel), .rd_en(rd_en), .rd_data(rd_data)
    );

    typedef struct {
        logic [7:0] exp;
        logic [7:0] msk;
        bit         tog;
        string      tag;
    } item_t;

    item_t      sbq[$];
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] last_rd = '0;

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; sel = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sel = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] e,
                      input logic [7:0] m, input bit t, input string tag);
        item_t it;
        it.exp = e; it.msk = m; it.tog = t; it.tag = tag;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        sbq.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic seq(input logic [11:0] a, input logic [7:0] d);
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h55);
        wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h55);
        wr(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                item_t it;
                bit    ok;
                #1;
                it = sbq.pop_front();
                checks++;
                if (it.tog) ok = (rd_data[6] != last_rd[6]);
                else        ok = ((rd_data & it.msk) == (it.exp & it.msk));
                if (!ok) begin
                    fails++;
                    if (it.tog)
                        $display("FAIL %s got %02h exp bit6=%0b", it.tag, rd_data, ~last_rd[6]);
                    else
                        $display("FAIL %s got %02h exp %02h mask %02h", it.tag, rd_data, it.exp, it.msk);
                end
                last_rd = rd_data;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        checks++;
        if (rd_data !== 8'h00) begin
            fails++;
            $display("FAIL R1 reset rd_data got %02h exp 00", rd_data);
        end
        rst_n = 1'b1;
        idle(2);
        rd(12'h000, 8'hA0, 8'hFF, 0, "R1 sector0 data");
        rd(12'h600, 8'hA3, 8'hFF, 0, "R1 sector3 data");

        // sector erase 1, extended window with sector 3
        seq(12'h200, 8'h30);
        rd(12'h200, 8'h00, 8'hBF, 0, "R4 window bit3 low");
        idle(20);
        wr(12'h600, 8'h30);
        idle(20);
        rd(12'h200, 8'h00, 8'hBF, 0, "R4 restarted window");
        rd(12'h200, 8'h00, 8'h00, 1, "R12 toggle a");
        idle(25);
        rd(12'h200, 8'h08, 8'hBF, 0, "R5 running bit3 high");
        wr(12'h555, 8'hAA);
        rd(12'h200, 8'h08, 8'hBF, 0, "R7 stray write ignored");
        rd(12'h200, 8'h00, 8'h00, 1, "R12 toggle b");
        idle(60);
        rd(12'h200, 8'hFF, 8'hFF, 0, "R5 sector1 erased");
        rd(12'h600, 8'hFF, 8'hFF, 0, "R5 sector3 erased");
        rd(12'h000, 8'hA0, 8'hFF, 0, "R5 sector0 kept");

        // corrupted unlock sequences
        seq(12'h000, 8'h31);
        rd(12'h000, 8'hA0, 8'hFF, 0, "R3 bad last byte");
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h56);
        wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h55);
        wr(12'h000, 8'h30);
        idle(70);
        rd(12'h000, 8'hA0, 8'hFF, 0, "R3 bad second byte");

        // abort inside window
        seq(12'h000, 8'h30);
        wr(12'h000, 8'h80);
        rd(12'h000, 8'hA0, 8'hFF, 0, "R6 abort to array");
        idle(80);
        rd(12'h000, 8'hA0, 8'hFF, 0, "R6 no erase later");
        seq(12'h800, 8'h30);
        wr(12'h801, 8'hB0);
        idle(70);
        rd(12'h800, 8'hA4, 8'hFF, 0, "R6 odd suspend aborts");

        // suspend inside window
        seq(12'h400, 8'h30);
        wr(12'h000, 8'hB0);
        rd(12'h000, 8'hA0, 8'hFF, 0, "R8 unmarked array");
        rd(12'h400, 8'h08, 8'hBF, 0, "R8 marked status");
        idle(80);
        rd(12'h400, 8'h08, 8'hBF, 0, "R8 window ended frozen");
        wr(12'h400, 8'h30);
        idle(60);
        rd(12'h400, 8'hFF, 8'hFF, 0, "R9 resumed from window");

        // suspend during erase
        seq(12'h800, 8'h30);
        idle(50);
        wr(12'h800, 8'hB0);
        rd(12'hA00, 8'hA5, 8'hFF, 0, "R8 other sector data");
        idle(80);
        rd(12'h800, 8'h08, 8'hBF, 0, "R8 erase frozen");
        wr(12'h800, 8'h30);
        idle(70);
        rd(12'h800, 8'hFF, 8'hFF, 0, "R9 resumed erase done");

        // reset during erase
        seq(12'hC00, 8'h30);
        idle(44);
        wr(12'h000, 8'h90);
        wr(12'h123, 8'h00);
        rd(12'hC00, 8'hA6, 8'hFF, 0, "R13 reset to array");
        idle(60);
        rd(12'hC00, 8'hA6, 8'hFF, 0, "R13 erase abandoned");

        // failing sector
        seq(12'hE00, 8'h30);
        idle(150);
        rd(12'hE00, 8'h28, 8'hBF, 0, "R11 fail bit5");
        wr(12'h000, 8'h55);
        rd(12'hE00, 8'h28, 8'hBF, 0, "R11 fail sticky");
        wr(12'h000, 8'h90);
        wr(12'h000, 8'h00);
        rd(12'hE00, 8'h00, 8'hFF, 0, "R10 preprogrammed zero");
        rd(12'h000, 8'hA0, 8'hFF, 0, "R13 back to array");

        // bulk erase
        seq(12'h555, 8'h10);
        idle(4);
        rd(12'h000, 8'h08, 8'hBF, 0, "R2 bulk bit3 high");
        wr(12'h000, 8'hB0);
        rd(12'h000, 8'h00, 8'h00, 1, "R7 bulk ignores suspend");
        wr(12'h000, 8'h90);
        wr(12'h000, 8'h00);
        rd(12'h000, 8'h08, 8'hBF, 0, "R7 bulk ignores reset");
        idle(150);
        rd(12'h000, 8'h28, 8'hBF, 0, "R2 bulk ends failed");
        wr(12'h000, 8'h90);
        wr(12'h000, 8'h00);
        rd(12'h200, 8'h00, 8'hFF, 0, "R2 sector1 zero");
        rd(12'h600, 8'h00, 8'hFF, 0, "R2 sector3 zero");

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule